// File: doc/BRIEF.md
# Packet-to-Cell Segmenter and Reassembler

This block converts a byte stream of packets into cells that can cross a switching fabric, and rebuilds packets from such cells on the far side. On the sending side it receives a packet one byte per cycle. It is told the packet's total length at the first byte. It cuts the packet into cells of at most 256 bytes and puts one header beat in front of each cell. The header carries everything the receiver needs to put the packet back together: source node, packet sequence number, cell index, first and last flags, and the cell's byte count. A packet marked as local never enters the fabric path. Its bytes go straight out of a separate local delivery port.

On the receiving side, a cell stream is decoded against one reassembly context per source node. A context remembers the next packet sequence number it will accept and the next cell index it will accept. Bytes of accepted cells stream out as a packet with start and end markers and the source number. A cell whose sequence number or index does not fit the context is dropped, and an error pulse is raised. Any packet already under way for that source is then abandoned. Packets are therefore never delivered out of order for any source. The cell output and cell input are separate ports, so the fabric, or a simple loopback, sits between them.

Top module: `cell_sar`

## Requirements
- R1: After reset, `pi_ready`, `co_valid`, `po_valid`, `po_err` and `lo_valid` are all low, and the first fabric packet uses sequence number 0.
- R2: A fabric packet of L bytes is cut into ceil(L/256) cells. Every cell except the final one holds exactly 256 bytes, and the final cell holds the remaining 1 to 256 bytes; for example, 257 bytes give cells of 256 and 1.
- R3: A header beat has `co_valid`=1 and `co_hdr`=1, and its 26-bit `co_hword` is laid out as follows: [25:22] source node (`NODE_ID`), [21:14] packet sequence number, [13:10] cell index, [9] first-cell flag, [8] last-cell flag, [7:0] cell byte count minus one. Each header beat is followed by exactly that many data beats (`co_hdr`=0, byte on `co_data`).
- R4: Within a packet, the cell index starts at 0 and rises by one per cell. The first flag is set only on index 0, and the last flag only on the final cell. The sequence number rises by one after every fabric packet.
- R5: `pi_ready` is low in the cycle where a start byte is first presented and in each cycle where a later cell's header is emitted, and high otherwise while a packet is in progress. A fabric packet therefore sees exactly one stall cycle per cell.
- R6: Cells looped from `co_*` back to `ci_*` come out on `po_*` as the original bytes, in the original order. `po_sop` is set on the first byte and `po_eop` on the last byte, and `po_src` equals the header's source.
- R7: A packet presented with `pi_local`=1 comes out on `lo_*` with its bytes, its start marker and its end marker unchanged. It produces no cell and does not advance the sequence number.
- R8: The reassembler keeps a separate context for each of the 16 sources, so cells of different sources may interleave at cell boundaries and still reassemble correctly.
- R9: A header is rejected if any of these holds: with no packet open for its source, it is not a first cell at index 0 carrying the expected sequence number; with a packet open, it is a first cell, or its sequence number or index differs from the expected one. On rejection, `po_err` pulses for one cycle with `po_src` set to that source, none of the cell's bytes appear on `po_*`, and the context closes the open packet without changing its expected sequence number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pi_valid | input | 1 | Packet input byte valid |
| pi_ready | output | 1 | Packet input can accept a byte this cycle |
| pi_data | input | 8 | Packet input byte |
| pi_sop | input | 1 | First byte of a packet |
| pi_eop | input | 1 | Last byte of a packet |
| pi_len | input | 12 | Packet length in bytes, valid with the first byte |
| pi_local | input | 1 | Packet is delivered locally, valid with the first byte |
| co_valid | output | 1 | Cell output beat valid |
| co_hdr | output | 1 | Cell output beat is a header |
| co_hword | output | 26 | Cell header word |
| co_data | output | 8 | Cell data byte |
| ci_valid | input | 1 | Cell input beat valid |
| ci_hdr | input | 1 | Cell input beat is a header |
| ci_hword | input | 26 | Cell input header word |
| ci_data | input | 8 | Cell input data byte |
| po_valid | output | 1 | Reassembled byte valid |
| po_data | output | 8 | Reassembled byte |
| po_sop | output | 1 | First byte of a reassembled packet |
| po_eop | output | 1 | Last byte of a reassembled packet |
| po_src | output | 4 | Source of the byte, or of the rejected cell when `po_err` is high |
| po_err | output | 1 | A cell header was rejected |
| lo_valid | output | 1 | Local delivery byte valid |
| lo_data | output | 8 | Local delivery byte |
| lo_sop | output | 1 | Local delivery first byte |
| lo_eop | output | 1 | Local delivery last byte |

## Verification
The assertions assume well-formed inputs. `pi_eop` arrives exactly on the byte that `pi_len` announced, and `pi_len` is never zero. On the cell input, a header beat is followed by exactly its stated number of data beats, and no data beat arrives outside a cell. The bench builds every packet from a single chosen length, so the length, the end marker and the byte count always agree. Injected cells are written with the same number of data beats as their count field says. This holds even for cells built to be rejected, so only the sequence and index rules are tested and the framing is always valid.

// File: rtl/cellsar_pkg.sv
package cellsar_pkg;
  parameter int CELL_MAX = 256;
  parameter int SRC_W    = 4;
  parameter int SEQ_W    = 8;
  parameter int IDX_W    = 4;
  parameter int LEN_W    = 12;

  localparam int CLEN_W = $clog2(CELL_MAX);
  localparam int HDR_W  = SRC_W + SEQ_W + IDX_W + 2 + CLEN_W;
  localparam int NSRC   = 1 << SRC_W;

  typedef struct packed {
    logic [SRC_W-1:0]  src;
    logic [SEQ_W-1:0]  seq;
    logic [IDX_W-1:0]  idx;
    logic              first;
    logic              last;
    logic [CLEN_W-1:0] lenm1;
  } cell_hdr_t;

  typedef struct packed {
    logic             busy;
    logic [SEQ_W-1:0] seq;
    logic [IDX_W-1:0] idx;
  } rx_ctx_t;

  // bytes carried by the next cell when rem bytes of the packet are left
  function automatic logic [CLEN_W:0] cell_bytes(input logic [LEN_W-1:0] rem);
    return (rem > LEN_W'(CELL_MAX)) ? (CLEN_W+1)'(CELL_MAX) : rem[CLEN_W:0];
  endfunction

  function automatic logic is_final_cell(input logic [LEN_W-1:0] rem);
    return rem <= LEN_W'(CELL_MAX);
  endfunction
endpackage

// File: rtl/cs_segmenter.sv
module cs_segmenter import cellsar_pkg::*; #(
  parameter logic [SRC_W-1:0] NODE_ID = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [LEN_W-1:0]  in_len,
  input  logic              in_local,
  output logic              cell_valid,
  output logic              cell_hdr,
  output logic [HDR_W-1:0]  cell_hword,
  output logic [7:0]        cell_data,
  output logic              lo_valid,
  output logic [7:0]        lo_data,
  output logic              lo_sop,
  output logic              lo_eop
);
  typedef enum logic [1:0] {S_IDLE, S_HDR, S_DATA, S_LOC} seg_st_t;
  localparam logic [CLEN_W:0] CNT_ONE = (CLEN_W+1)'(1);
  localparam logic [LEN_W-1:0] REM_ONE = LEN_W'(1);

  seg_st_t            st;
  logic [LEN_W-1:0]   rem;
  logic [CLEN_W:0]    ccnt;
  logic [IDX_W-1:0]   idx;
  logic [SEQ_W-1:0]   seq;
  logic               lo_first;

  // named events for the checks
  logic start_pkt, acc_byte, cell_done;
  assign in_ready  = (st == S_DATA) || (st == S_LOC);
  assign acc_byte  = in_valid && in_ready;
  assign start_pkt = (st == S_IDLE) && in_valid && in_sop;
  assign cell_done = (st == S_DATA) && acc_byte && (ccnt == CNT_ONE);

  function automatic cell_hdr_t make_hdr(input logic [LEN_W-1:0] r,
                                         input logic [IDX_W-1:0] ix,
                                         input logic [SEQ_W-1:0] sq);
    cell_hdr_t h;
    logic [CLEN_W:0] n;
    n       = cell_bytes(r);
    h.src   = NODE_ID;
    h.seq   = sq;
    h.idx   = ix;
    h.first = (ix == '0);
    h.last  = is_final_cell(r);
    h.lenm1 = CLEN_W'(n - 1'b1);
    return h;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; rem <= '0; ccnt <= '0; idx <= '0; seq <= '0; lo_first <= 1'b0;
      cell_valid <= 1'b0; cell_hdr <= 1'b0; cell_hword <= '0; cell_data <= '0;
      lo_valid <= 1'b0; lo_data <= '0; lo_sop <= 1'b0; lo_eop <= 1'b0;
    end else begin
      cell_valid <= 1'b0;
      cell_hdr   <= 1'b0;
      lo_valid   <= 1'b0;
      case (st)
        S_IDLE: if (start_pkt) begin
          if (in_local) begin
            st       <= S_LOC;
            lo_first <= 1'b1;
          end else begin
            cell_valid <= 1'b1;
            cell_hdr   <= 1'b1;
            cell_hword <= make_hdr(in_len, '0, seq);
            rem        <= in_len;
            ccnt       <= cell_bytes(in_len);
            idx        <= '0;
            st         <= S_DATA;
          end
        end
        S_HDR: begin
          cell_valid <= 1'b1;
          cell_hdr   <= 1'b1;
          cell_hword <= make_hdr(rem, idx, seq);
          ccnt       <= cell_bytes(rem);
          st         <= S_DATA;
        end
        S_DATA: if (acc_byte) begin
          cell_valid <= 1'b1;
          cell_data  <= in_data;
          rem        <= rem - 1'b1;
          ccnt       <= ccnt - 1'b1;
          if (cell_done) begin
            if (rem == REM_ONE) begin
              st  <= S_IDLE;
              seq <= seq + 1'b1;
            end else begin
              st  <= S_HDR;
              idx <= idx + 1'b1;
            end
          end
        end
        S_LOC: if (acc_byte) begin
          lo_valid <= 1'b1;
          lo_data  <= in_data;
          lo_sop   <= lo_first;
          lo_eop   <= in_eop;
          lo_first <= 1'b0;
          if (in_eop) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  cell_hdr_t out_h;
  assign out_h = cell_hdr_t'(cell_hword);

  // R5
  hdr_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_valid && cell_hdr |-> $past(!in_ready));
  // R2
  full_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_valid && cell_hdr && !out_h.last |-> out_h.lenm1 == '1);
  // R6
  eop_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA) && acc_byte && in_eop |-> rem == REM_ONE);
  // R7
  loc_no_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_valid |-> !cell_valid);
endmodule

// File: rtl/cs_ctx_store.sv
module cs_ctx_store import cellsar_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] rd_addr,
  output rx_ctx_t          rd_data,
  input  logic             wr_en,
  input  logic [SRC_W-1:0] wr_addr,
  input  rx_ctx_t          wr_data
);
  rx_ctx_t ent [NSRC];

  for (genvar g = 0; g < NSRC; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               ent[g] <= '0;
      else if (wr_en && wr_addr == SRC_W'(g))   ent[g] <= wr_data;
    end
  end

  assign rd_data = ent[rd_addr];
endmodule

// File: rtl/cs_reassembler.sv
module cs_reassembler import cellsar_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             c_valid,
  input  logic             c_hdr,
  input  logic [HDR_W-1:0] c_hword,
  input  logic [7:0]       c_data,
  output logic             p_valid,
  output logic [7:0]       p_data,
  output logic             p_sop,
  output logic             p_eop,
  output logic [SRC_W-1:0] p_src,
  output logic             p_err
);
  localparam logic [CLEN_W:0] CNT_ONE = (CLEN_W+1)'(1);

  cell_hdr_t        h;
  rx_ctx_t          rd, nxt;
  logic             hdr_in, ok, acc_hdr, rej_hdr, data_in;
  logic             pass, sop_pend, cur_last;
  logic [SRC_W-1:0] cur_src;
  logic [CLEN_W:0]  left;

  assign h       = cell_hdr_t'(c_hword);
  assign hdr_in  = c_valid && c_hdr;
  assign data_in = c_valid && !c_hdr;
  assign ok      = rd.busy ? (!h.first && h.seq == rd.seq && h.idx == rd.idx)
                           : ( h.first && h.idx == '0 && h.seq == rd.seq);
  assign acc_hdr = hdr_in && ok;
  assign rej_hdr = hdr_in && !ok;

  always_comb begin
    nxt = rd;
    if (!ok) begin
      nxt.busy = 1'b0;
      nxt.idx  = '0;
    end else if (h.last) begin
      nxt.busy = 1'b0;
      nxt.idx  = '0;
      nxt.seq  = rd.seq + 1'b1;
    end else begin
      nxt.busy = 1'b1;
      nxt.idx  = rd.idx + 1'b1;
    end
  end

  cs_ctx_store u_ctx (
    .clk(clk), .rst_n(rst_n),
    .rd_addr(h.src), .rd_data(rd),
    .wr_en(hdr_in), .wr_addr(h.src), .wr_data(nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass <= 1'b0; sop_pend <= 1'b0; cur_last <= 1'b0; cur_src <= '0; left <= '0;
      p_valid <= 1'b0; p_data <= '0; p_sop <= 1'b0; p_eop <= 1'b0; p_src <= '0; p_err <= 1'b0;
    end else begin
      p_valid <= 1'b0;
      p_err   <= 1'b0;
      if (hdr_in) begin
        pass     <= ok;
        sop_pend <= h.first;
        cur_last <= h.last;
        cur_src  <= h.src;
        left     <= {1'b0, h.lenm1} + 1'b1;
        if (!ok) begin
          p_err <= 1'b1;
          p_src <= h.src;
        end
      end else if (data_in) begin
        left <= left - 1'b1;
        if (pass) begin
          p_valid  <= 1'b1;
          p_data   <= c_data;
          p_sop    <= sop_pend;
          p_eop    <= cur_last && (left == CNT_ONE);
          p_src    <= cur_src;
          sop_pend <= 1'b0;
        end
      end
    end
  end

  // R9
  reject_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rej_hdr |=> p_err);
  // R9
  err_from_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_err |-> $past(hdr_in));
  // R6
  byte_from_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_valid |-> $past(data_in) && !p_err);
  // R6
  beat_in_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_in |-> left != '0);
endmodule

// File: rtl/cell_sar.sv
module cell_sar import cellsar_pkg::*; #(
  parameter logic [SRC_W-1:0] NODE_ID = SRC_W'(1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pi_valid,
  output logic             pi_ready,
  input  logic [7:0]       pi_data,
  input  logic             pi_sop,
  input  logic             pi_eop,
  input  logic [LEN_W-1:0] pi_len,
  input  logic             pi_local,
  output logic             co_valid,
  output logic             co_hdr,
  output logic [HDR_W-1:0] co_hword,
  output logic [7:0]       co_data,
  input  logic             ci_valid,
  input  logic             ci_hdr,
  input  logic [HDR_W-1:0] ci_hword,
  input  logic [7:0]       ci_data,
  output logic             po_valid,
  output logic [7:0]       po_data,
  output logic             po_sop,
  output logic             po_eop,
  output logic [SRC_W-1:0] po_src,
  output logic             po_err,
  output logic             lo_valid,
  output logic [7:0]       lo_data,
  output logic             lo_sop,
  output logic             lo_eop
);
  cs_segmenter #(.NODE_ID(NODE_ID)) u_seg (
    .clk(clk), .rst_n(rst_n),
    .in_valid(pi_valid), .in_ready(pi_ready), .in_data(pi_data),
    .in_sop(pi_sop), .in_eop(pi_eop), .in_len(pi_len), .in_local(pi_local),
    .cell_valid(co_valid), .cell_hdr(co_hdr), .cell_hword(co_hword), .cell_data(co_data),
    .lo_valid(lo_valid), .lo_data(lo_data), .lo_sop(lo_sop), .lo_eop(lo_eop)
  );

  cs_reassembler u_rsm (
    .clk(clk), .rst_n(rst_n),
    .c_valid(ci_valid), .c_hdr(ci_hdr), .c_hword(ci_hword), .c_data(ci_data),
    .p_valid(po_valid), .p_data(po_data), .p_sop(po_sop), .p_eop(po_eop),
    .p_src(po_src), .p_err(po_err)
  );
endmodule

// File: tb/test_cell_sar.sv
module test_cell_sar;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pi_valid = 1'b0, pi_sop = 1'b0, pi_eop = 1'b0, pi_local = 1'b0;
  logic [7:0]  pi_data = '0;
  logic [11:0] pi_len = '0;
  logic        pi_ready;
  logic        co_valid, co_hdr;
  logic [25:0] co_hword;
  logic [7:0]  co_data;
  logic        ci_valid, ci_hdr;
  logic [25:0] ci_hword;
  logic [7:0]  ci_data;
  logic        po_valid, po_sop, po_eop, po_err;
  logic [7:0]  po_data;
  logic [3:0]  po_src;
  logic        lo_valid, lo_sop, lo_eop;
  logic [7:0]  lo_data;

  logic        inj_mode = 1'b0, inj_valid = 1'b0, inj_hdr = 1'b0;
  logic [25:0] inj_hword = '0;
  logic [7:0]  inj_data = '0;

  assign ci_valid = inj_mode ? inj_valid : co_valid;
  assign ci_hdr   = inj_mode ? inj_hdr   : co_hdr;
  assign ci_hword = inj_mode ? inj_hword : co_hword;
  assign ci_data  = inj_mode ? inj_data  : co_data;

  localparam logic [3:0] NODE = 4'd1;

  cell_sar #(.NODE_ID(NODE)) i_cell_sar (
    .clk(clk), .rst_n(rst_n),
    .pi_valid(pi_valid), .pi_ready(pi_ready), .pi_data(pi_data), .pi_sop(pi_sop),
    .pi_eop(pi_eop), .pi_len(pi_len), .pi_local(pi_local),
    .co_valid(co_valid), .co_hdr(co_hdr), .co_hword(co_hword), .co_data(co_data),
    .ci_valid(ci_valid), .ci_hdr(ci_hdr), .ci_hword(ci_hword), .ci_data(ci_data),
    .po_valid(po_valid), .po_data(po_data), .po_sop(po_sop), .po_eop(po_eop),
    .po_src(po_src), .po_err(po_err),
    .lo_valid(lo_valid), .lo_data(lo_data), .lo_sop(lo_sop), .lo_eop(lo_eop)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int seq_model = 0;
  int err_cnt = 0, po_cnt = 0, co_cnt = 0;
  logic [3:0]  err_src = '0;
  logic [25:0] last_hdr = '0;
  logic [13:0] q_po[$];
  logic [9:0]  q_lo[$];
  logic [25:0] q_hdr[$];
  int          cell_lens[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [25:0] exp_hdr(input int sq, input int ix, input int total);
    int rem = total - ix * 256;
    int n = (rem > 256) ? 256 : rem;
    logic [25:0] w;
    w = '0;
    w[25:22] = NODE;
    w[21:14] = 8'(sq);
    w[13:10] = 4'(ix);
    w[9]     = (ix == 0);
    w[8]     = (rem <= 256);
    w[7:0]   = 8'(n - 1);
    return w;
  endfunction

  // output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (co_valid) co_cnt++;
      if (co_valid && co_hdr) begin
        last_hdr = co_hword;
        cell_lens.push_back(int'(co_hword[7:0]) + 1);
        if (q_hdr.size() == 0) chk(1'b0, "R3", longint'(co_hword), 0);
        else begin
          logic [25:0] e;
          e = q_hdr.pop_front();
          chk(co_hword == e, "R3", longint'(co_hword), longint'(e));
        end
      end
      if (po_valid) begin
        po_cnt++;
        if (q_po.size() == 0) chk(1'b0, "R6", longint'({po_src, po_sop, po_eop, po_data}), 0);
        else begin
          logic [13:0] e;
          e = q_po.pop_front();
          chk({po_src, po_sop, po_eop, po_data} == e, "R6",
              longint'({po_src, po_sop, po_eop, po_data}), longint'(e));
        end
      end
      if (po_err) begin
        err_cnt++;
        err_src = po_src;
      end
      if (lo_valid) begin
        if (q_lo.size() == 0) chk(1'b0, "R7", longint'({lo_sop, lo_eop, lo_data}), 0);
        else begin
          logic [9:0] e;
          e = q_lo.pop_front();
          chk({lo_sop, lo_eop, lo_data} == e, "R7", longint'({lo_sop, lo_eop, lo_data}), longint'(e));
        end
      end
    end
  end

  task automatic drain(input string req);
    for (int k = 0; k < 2000; k++) begin
      if (q_po.size() == 0 && q_lo.size() == 0 && q_hdr.size() == 0) break;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk(q_po.size() == 0 && q_lo.size() == 0 && q_hdr.size() == 0, req,
        longint'(q_po.size() + q_lo.size() + q_hdr.size()), 0);
  endtask

  task automatic send_pkt(input int len, input bit is_loc);
    int stalls = 0;
    int cells = (len + 255) / 256;
    if (!is_loc) begin
      for (int c = 0; c < cells; c++) q_hdr.push_back(exp_hdr(seq_model, c, len));
      seq_model++;
    end
    @(negedge clk);
    for (int i = 0; i < len; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      pi_valid = 1'b1; pi_data = d; pi_sop = (i == 0); pi_eop = (i == len - 1);
      pi_len = 12'(len); pi_local = is_loc;
      if (is_loc) q_lo.push_back({pi_sop, pi_eop, d});
      else        q_po.push_back({NODE, pi_sop, pi_eop, d});
      while (!pi_ready) begin
        stalls++;
        @(negedge clk);
      end
      @(negedge clk);
    end
    pi_valid = 1'b0; pi_sop = 1'b0; pi_eop = 1'b0; pi_local = 1'b0;
    // R5: one stall per cell, one for a local packet
    chk(stalls == (is_loc ? 1 : cells), "R5", stalls, is_loc ? 1 : cells);
  endtask

  task automatic inj_cell(input int src, input int sq, input int ix, input bit first,
                          input bit last, input int n, input bit keep);
    @(negedge clk);
    inj_valid = 1'b1; inj_hdr = 1'b1;
    inj_hword = {4'(src), 8'(sq), 4'(ix), first, last, 8'(n - 1)};
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      @(negedge clk);
      d = 8'($urandom);
      inj_hdr = 1'b0; inj_data = d;
      if (keep) q_po.push_back({4'(src), first && (k == 0), last && (k == n - 1), d});
    end
    @(negedge clk);
    inj_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk(pi_ready == 1'b0, "R1", pi_ready, 0);
    chk(co_valid == 1'b0, "R1", co_valid, 0);
    chk(po_valid == 1'b0 && po_err == 1'b0, "R1", {po_valid, po_err}, 0);
    chk(lo_valid == 1'b0, "R1", lo_valid, 0);
  endtask

  task automatic t_edges;
    int lens[7] = '{1, 255, 256, 257, 512, 513, 2048};
    foreach (lens[j]) begin
      cell_lens.delete();
      send_pkt(lens[j], 1'b0);
      drain("R6");
      if (lens[j] == 257) begin
        // R2: 257 bytes give 256 then 1
        chk(cell_lens.size() == 2, "R2", cell_lens.size(), 2);
        if (cell_lens.size() == 2) begin
          chk(cell_lens[0] == 256, "R2", cell_lens[0], 256);
          chk(cell_lens[1] == 1, "R2", cell_lens[1], 1);
        end
      end
      if (lens[j] == 2048) begin
        // R4: eighth cell, index 7, last only
        chk(last_hdr[13:10] == 4'd7 && last_hdr[9:8] == 2'b01, "R4",
            longint'(last_hdr[13:8]), longint'({4'd7, 2'b01}));
        chk(cell_lens.size() == 8, "R2", cell_lens.size(), 8);
      end
    end
    // R1: the first packet after reset used sequence 0, so the seventh uses 6
    chk(last_hdr[21:14] == 8'd6, "R1", longint'(last_hdr[21:14]), 6);
  endtask

  task automatic t_random;
    for (int j = 0; j < 16; j++) begin
      send_pkt(int'($urandom_range(2048, 1)), 1'b0);
    end
    drain("R6");
  endtask

  task automatic t_local;
    int c0, s0;
    c0 = co_cnt;
    s0 = seq_model;
    send_pkt(10, 1'b1);
    send_pkt(300, 1'b1);
    drain("R7");
    chk(co_cnt == c0, "R7", co_cnt, c0);
    // next fabric packet carries the sequence number that follows the last fabric one
    send_pkt(3, 1'b0);
    drain("R6");
    chk(last_hdr[21:14] == 8'(s0), "R4", longint'(last_hdr[21:14]), s0);
  endtask

  task automatic t_inject;
    int e0, p0;
    inj_mode = 1'b1;
    inj_cell(3, 0, 0, 1, 1, 5, 1);
    drain("R6");
    // R9: wrong sequence number
    e0 = err_cnt; p0 = po_cnt;
    inj_cell(3, 2, 0, 1, 1, 3, 0);
    repeat (3) @(negedge clk);
    chk(err_cnt == e0 + 1, "R9", err_cnt, e0 + 1);
    chk(err_src == 4'd3, "R9", err_src, 3);
    chk(po_cnt == p0, "R9", po_cnt, p0);
    // R9: skipped index, then a middle cell with no packet open
    inj_cell(3, 1, 0, 1, 0, 256, 1);
    drain("R6");
    e0 = err_cnt; p0 = po_cnt;
    inj_cell(3, 1, 2, 0, 0, 4, 0);
    inj_cell(3, 1, 1, 0, 1, 2, 0);
    repeat (3) @(negedge clk);
    chk(err_cnt == e0 + 2, "R9", err_cnt, e0 + 2);
    chk(po_cnt == p0, "R9", po_cnt, p0);
    // R9: expected sequence kept, so packet 1 is accepted on retry
    e0 = err_cnt;
    inj_cell(3, 1, 0, 1, 1, 2, 1);
    drain("R9");
    chk(err_cnt == e0, "R9", err_cnt, e0);
    // R8: interleaved sources
    inj_cell(5, 0, 0, 1, 0, 3, 1);
    inj_cell(6, 0, 0, 1, 1, 2, 1);
    inj_cell(5, 0, 1, 0, 1, 1, 1);
    drain("R8");
    chk(err_cnt == e0, "R8", err_cnt, e0);
    inj_mode = 1'b0;
  endtask

  bit done = 1'b0;

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_edges();
    t_random();
    t_local();
    t_inject();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule